// File: doc/BRIEF.md
# Indexed-Colour Raster Scanout

This block drives a 640x480 progressive display from a pixel clock of about 25 MHz. The nominal rate is 25.175 MHz. Two 10-bit counters track the horizontal and vertical position. From them the block derives active-low horizontal sync, vertical sync and blank. A raster-order pixel address walks the visible area, one step per visible pixel.

Colour is produced by two chained registered reads. The pixel address selects an 8-bit colour index from an image store. That index selects a 24-bit entry from a 256-entry palette. Red is taken from bits 23:16, green from 15:8 and blue from 7:0. The control signals pass through a two-stage delay line, so every pin carries the same pixel in the same cycle.

Both stores have plain synchronous write ports. Software or a bench fills them, typically while reset is held. The image store depth is a parameter. At the default depth the image repeats as a tile across the frame. A depth of 2^19 covers every pixel.

Top module: `indexed_scanout`

## Requirements
- R1: A line lasts H_VIS+H_FP+H_SW+H_BP clocks (800 by default) and a frame lasts V_VIS+V_FP+V_SW+V_BP lines (525 by default), after which the pattern repeats.
- R2: hsync_n is low exactly for line positions H_VIS+H_FP up to H_VIS+H_FP+H_SW-1 (656..751 by default), otherwise high.
- R3: vsync_n is low exactly on lines V_VIS+V_FP up to V_VIS+V_FP+V_SW-1 (490..491 by default), for every clock of those lines.
- R4: blank_n is high only for positions with h < H_VIS and v < V_VIS; the pixel address advances by one per visible pixel in raster order, a = v*H_VIS + h.
- R5: The pixel address is zero throughout vertical blanking, so every frame restarts at address 0.
- R6: A visible pixel shows palette[image[a mod 2^IMG_AW]], with red = bits 23:16, green = bits 15:8 and blue = bits 7:0 of the palette entry.
- R7: Colour, hsync_n, vsync_n, blank_n and sync_n for the counter position of one cycle all appear together two clock edges later; the output after the second rising edge following reset release is pixel (0,0).
- R8: red, grn and blu are zero whenever blank_n is low.
- R9: sync_n is low whenever hsync_n or vsync_n is low, and high otherwise.
- R10: While rst is high, and up to the first edge after its release, the outputs read hsync_n=1, vsync_n=1, sync_n=1, blank_n=0 and colour 0.
- R11: A write to either store takes effect for reads in later cycles, and reset leaves store contents untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| img_we | input | 1 | Image store write enable |
| img_waddr | input | IMG_AW | Image store write address |
| img_wdata | input | 8 | Colour index to store |
| pal_we | input | 1 | Palette write enable |
| pal_waddr | input | 8 | Palette entry to write |
| pal_wdata | input | 24 | Palette colour, red 23:16, green 15:8, blue 7:0 |
| red | output | 8 | Red component |
| grn | output | 8 | Green component |
| blu | output | 8 | Blue component |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank_n | output | 1 | Low during retrace and porches |
| sync_n | output | 1 | Combined sync, active low |

## Verification
Every output is due exactly two rising edges after the counters reach the matching position. The first edge after reset release therefore still shows the reset values, and edge n shows raster position n-2. The bench counts edges from release and samples on the falling edge after each one. It compares all pins against a model evaluated at position n-2, computed from its own copy of the stored contents. Store rewrites are made under reset, so the next frames must show the new data from their first pixel.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;
  localparam int COLOR_W   = 8;
  localparam int PAL_DEPTH = 1 << COLOR_W;

  typedef logic [COLOR_W-1:0] cidx_t;

  typedef struct packed {
    logic [COLOR_W-1:0] red;
    logic [COLOR_W-1:0] grn;
    logic [COLOR_W-1:0] blu;
  } rgb_t;
endpackage

// File: rtl/scan_timing.sv
`timescale 1ns/1ps
module scan_timing #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SW   = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SW   = 2,
  parameter int V_BP   = 33,
  parameter int CNT_W  = 10,
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] addr_o,
  output logic              vis_o,
  output logic              hs_o,
  output logic              vs_o
);
  localparam int H_TOT = H_VIS + H_FP + H_SW + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SW + V_BP;
  localparam logic [CNT_W-1:0] H_LAST  = CNT_W'(H_TOT - 1);
  localparam logic [CNT_W-1:0] V_LAST  = CNT_W'(V_TOT - 1);
  localparam logic [CNT_W-1:0] H_VEND  = CNT_W'(H_VIS);
  localparam logic [CNT_W-1:0] V_VEND  = CNT_W'(V_VIS);
  localparam logic [CNT_W-1:0] H_VLAST = CNT_W'(H_VIS - 1);
  localparam logic [CNT_W-1:0] V_VLAST = CNT_W'(V_VIS - 1);
  localparam logic [CNT_W-1:0] H_SBEG  = CNT_W'(H_VIS + H_FP);
  localparam logic [CNT_W-1:0] H_SEND  = CNT_W'(H_VIS + H_FP + H_SW);
  localparam logic [CNT_W-1:0] V_SBEG  = CNT_W'(V_VIS + V_FP);
  localparam logic [CNT_W-1:0] V_SEND  = CNT_W'(V_VIS + V_FP + V_SW);

  logic [CNT_W-1:0]  hpos, vpos;
  logic [ADDR_W-1:0] addr_q;
  logic              frame_end_px;

  always_comb begin
    vis_o        = (hpos < H_VEND) && (vpos < V_VEND);
    hs_o         = (hpos >= H_SBEG) && (hpos < H_SEND);
    vs_o         = (vpos >= V_SBEG) && (vpos < V_SEND);
    frame_end_px = vis_o && (hpos == H_VLAST) && (vpos == V_VLAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hpos   <= '0;
      vpos   <= '0;
      addr_q <= '0;
    end else begin
      if (hpos == H_LAST) begin
        hpos <= '0;
        vpos <= (vpos == V_LAST) ? '0 : vpos + CNT_W'(1);
      end else begin
        hpos <= hpos + CNT_W'(1);
      end
      if (vis_o) addr_q <= frame_end_px ? '0 : addr_q + ADDR_W'(1);
    end
  end

  assign addr_o = addr_q;

  // R1
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    (hpos <= H_LAST) && (vpos <= V_LAST));

  // R1
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    (hpos != '0) |-> $stable(vpos));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vis_o |=> $stable(addr_q));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (vis_o && !frame_end_px) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

  // R5
  addr_home_chk: assert property (@(posedge clk) disable iff (rst)
    (vpos >= V_VEND) |-> (addr_q == '0));
endmodule

// File: rtl/scan_lookup.sv
`timescale 1ns/1ps
module scan_lookup import scan_pkg::*; #(
  parameter int IMG_AW = 12,
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              img_we,
  input  logic [IMG_AW-1:0] img_waddr,
  input  cidx_t             img_wdata,
  input  logic              pal_we,
  input  cidx_t             pal_waddr,
  input  rgb_t              pal_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output rgb_t              pix_o
);
  localparam int IMG_DEPTH = 1 << IMG_AW;

  cidx_t             img_mem [IMG_DEPTH];
  rgb_t              pal_mem [PAL_DEPTH];
  logic [IMG_AW-1:0] img_raddr;
  cidx_t             idx_q;
  rgb_t              pix_q;

  // wrap the raster address onto the image store depth
  assign img_raddr = IMG_AW'(32'(rd_addr) % 32'(IMG_DEPTH));

  always_ff @(posedge clk) begin
    if (img_we) img_mem[img_waddr] <= img_wdata;
    if (pal_we) pal_mem[pal_waddr] <= pal_wdata;
  end

  // stage 1: index fetch, stage 2: palette fetch
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      pix_q <= '0;
    end else begin
      idx_q <= img_mem[img_raddr];
      pix_q <= pal_mem[idx_q];
    end
  end

  assign pix_o = pix_q;

  // R11
  idx_known_chk: assert property (@(posedge clk) disable iff (rst)
    img_we |=> (img_mem[$past(img_waddr)] == $past(img_wdata)));
endmodule

// File: rtl/scan_align.sv
`timescale 1ns/1ps
module scan_align #(
  parameter int             W       = 3,
  parameter int             DEPTH   = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign dout = stg_q[DEPTH-1];
endmodule

// File: rtl/indexed_scanout.sv
`timescale 1ns/1ps
module indexed_scanout import scan_pkg::*; #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SW   = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SW   = 2,
  parameter int V_BP   = 33,
  parameter int CNT_W  = 10,
  parameter int IMG_AW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              img_we,
  input  logic [IMG_AW-1:0] img_waddr,
  input  logic [7:0]        img_wdata,
  input  logic              pal_we,
  input  logic [7:0]        pal_waddr,
  input  logic [23:0]       pal_wdata,
  output logic [7:0]        red,
  output logic [7:0]        grn,
  output logic [7:0]        blu,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              blank_n,
  output logic              sync_n
);
  localparam int ADDR_W    = $clog2(H_VIS * V_VIS);
  localparam int READ_LAT  = 2;
  localparam int CTL_W     = 3;

  logic [ADDR_W-1:0] pix_addr;
  logic              vis, hs, vs;
  logic [CTL_W-1:0]  raw_ctl, dly_ctl;
  rgb_t              pix;
  logic [1:0]        prime_q;

  scan_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP),
    .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_timing (
    .clk(clk), .rst(rst), .addr_o(pix_addr),
    .vis_o(vis), .hs_o(hs), .vs_o(vs)
  );

  scan_lookup #(.IMG_AW(IMG_AW), .ADDR_W(ADDR_W)) u_lookup (
    .clk(clk), .rst(rst),
    .img_we(img_we), .img_waddr(img_waddr), .img_wdata(img_wdata),
    .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
    .rd_addr(pix_addr), .pix_o(pix)
  );

  // control bits: {blank_n, hsync_n, vsync_n}
  assign raw_ctl = {vis, ~hs, ~vs};

  scan_align #(.W(CTL_W), .DEPTH(READ_LAT), .RST_VAL(3'b011)) u_align (
    .clk(clk), .rst(rst), .din(raw_ctl), .dout(dly_ctl)
  );

  assign {blank_n, hsync_n, vsync_n} = dly_ctl;
  assign sync_n = hsync_n & vsync_n;
  assign red    = blank_n ? pix.red : '0;
  assign grn    = blank_n ? pix.grn : '0;
  assign blu    = blank_n ? pix.blu : '0;

  // edges since reset, only to gate the latency checks
  always_ff @(posedge clk) begin
    if (rst)                   prime_q <= '0;
    else if (prime_q != 2'd2)  prime_q <= prime_q + 2'd1;
  end

  // R7
  ctl_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (prime_q == 2'd2) |-> (dly_ctl == $past(raw_ctl, 2)));

  // R8
  blank_black_chk: assert property (@(posedge clk) disable iff (rst)
    ((prime_q == 2'd2) && !$past(vis, 2)) |-> ({red, grn, blu} == 24'd0));

  // R10
  reset_out_chk: assert property (@(posedge clk)
    rst |=> (!blank_n && hsync_n && vsync_n && sync_n));

  // R9
  sync_comb_chk: assert property (@(posedge clk) disable iff (rst)
    (!hsync_n || !vsync_n) |-> !sync_n);
endmodule

// File: tb/indexed_scanout_tb.sv
`timescale 1ns/1ps
module indexed_scanout_tb;
  localparam int HA = 8, HF = 2, HS = 3, HB = 2;
  localparam int VA = 4, VF = 1, VS = 2, VB = 1;
  localparam int IAW = 5;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FRAME = HT * VT;
  localparam int IDEPTH = 1 << IAW;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           img_we = 1'b0;
  logic [IAW-1:0] img_waddr = '0;
  logic [7:0]     img_wdata = '0;
  logic           pal_we = 1'b0;
  logic [7:0]     pal_waddr = '0;
  logic [23:0]    pal_wdata = '0;
  logic [7:0]     red, grn, blu;
  logic           hsync_n, vsync_n, blank_n, sync_n;

  logic [7:0]  img_m [IDEPTH];
  logic [23:0] pal_m [256];
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  indexed_scanout #(
    .H_VIS(HA), .H_FP(HF), .H_SW(HS), .H_BP(HB),
    .V_VIS(VA), .V_FP(VF), .V_SW(VS), .V_BP(VB),
    .CNT_W(10), .IMG_AW(IAW)
  ) u_dut (
    .clk(clk), .rst(rst),
    .img_we(img_we), .img_waddr(img_waddr), .img_wdata(img_wdata),
    .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
    .red(red), .grn(grn), .blu(blu),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .blank_n(blank_n), .sync_n(sync_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_reset_vals(input string tag);
    chk({tag, " rgb"},     32'({red, grn, blu}), 32'd0);
    chk({tag, " hsync_n"}, 32'(hsync_n), 32'd1);
    chk({tag, " vsync_n"}, 32'(vsync_n), 32'd1);
    chk({tag, " blank_n"}, 32'(blank_n), 32'd0);
    chk({tag, " sync_n"},  32'(sync_n),  32'd1);
  endtask

  // expected pins for raster position p counted from reset release
  task automatic chk_pos(input int p);
    int h, v, a;
    logic vis, hs, vs;
    logic [23:0] exp_rgb;
    h   = p % HT;
    v   = (p / HT) % VT;
    vis = (h < HA) && (v < VA);
    hs  = (h >= HA + HF) && (h < HA + HF + HS);
    vs  = (v >= VA + VF) && (v < VA + VF + VS);
    a   = v * HA + h;
    exp_rgb = vis ? pal_m[img_m[a % IDEPTH]] : 24'd0;
    if (!vis)              chk("R8 rgb zero in blank", 32'({red, grn, blu}), 32'(exp_rgb));
    else if (p >= FRAME)   chk("R5 R6 rgb next frame", 32'({red, grn, blu}), 32'(exp_rgb));
    else                   chk("R6 R7 rgb", 32'({red, grn, blu}), 32'(exp_rgb));
    chk("R1 R2 hsync_n", 32'(hsync_n), 32'(!hs));
    chk("R3 vsync_n",    32'(vsync_n), 32'(!vs));
    chk("R4 blank_n",    32'(blank_n), 32'(vis));
    chk("R9 sync_n",     32'(sync_n),  32'(!(hs || vs)));
  endtask

  task automatic load_image(input int seed);
    for (int a = 0; a < IDEPTH; a++) begin
      @(negedge clk);
      img_we = 1'b1; img_waddr = IAW'(a); img_wdata = 8'(a * 7 + seed);
      img_m[a] = 8'(a * 7 + seed);
    end
    @(negedge clk);
    img_we = 1'b0;
  endtask

  task automatic load_palette(input int seed);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      pal_we = 1'b1; pal_waddr = 8'(i);
      pal_wdata = {8'(i ^ seed), 8'(~i), 8'(i + seed)};
      pal_m[i]  = {8'(i ^ seed), 8'(~i), 8'(i + seed)};
    end
    @(negedge clk);
    pal_we = 1'b0;
  endtask

  // release reset at a falling edge; edge n then shows position n-2 (R7)
  task automatic run_frames(input int nf);
    @(negedge clk);
    rst = 1'b0;
    for (int n = 1; n <= nf * FRAME + 2; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (n == 1) chk_reset_vals("R10 R7 first edge");
      else        chk_pos(n - 2);
    end
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    load_image(3);
    load_palette(8'h5A);
    repeat (2) @(negedge clk);
    chk_reset_vals("R10 held");
  endtask

  task automatic t_two_frames();
    run_frames(2);
  endtask

  task automatic t_palette_swap();
    // R11: new palette written under reset, image store kept
    load_palette(8'hC3);
    run_frames(1);
  endtask

  task automatic t_image_swap();
    // R11 and R5: new image, two frames from address 0
    load_image(8'h41);
    run_frames(2);
  endtask

  initial begin
    t_reset_state();
    t_two_frames();
    t_palette_swap();
    t_image_swap();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule